// File: doc/BRIEF.md
# Coprocessor status set/clear register

This block holds the run-control and flag state of a slave signal processor. Software changes it through one write-only command word. Each flag has a clear bit and a set bit of its own, so one write can change any mix of flags without a read-modify-write. The block shows the status as a parallel word and drives an interrupt line. When software releases the processor from halt or break, it also drives a one-cycle task-start pulse.

The processor core reports a break by pulsing the break-event input. That sets the broke flag, and it raises the interrupt when interrupt-on-break is enabled. Halt and broke together form a four-state run-control machine:

- RS_HALT: halt=1, broke=0. This is the reset state.
- RS_HALT_BRK: both flags set.
- RS_BROKE: broke only.
- RS_RUN: both flags clear.

The transitions are named as follows:

- T_STOP sets halt.
- T_BREAK is taken on a break event.
- T_RESUME reaches RS_RUN through a halt-clear or broke-clear command. It is the only transition that issues a task-start pulse.
- T_REARM is a halt-clear or broke-clear command that leaves one of the two flags set. It issues no pulse.

Top module: `ssp_status_reg`

## Requirements
- R1: Halt is status bit 0. Command bit 0 clears it and command bit 1 sets it. When both bits are in one write, halt ends up set.
- R2: Broke is status bit 1. Command bit 2 clears it, and no command bit sets it. A break event sets it, and a break event in the same cycle as a broke-clear command leaves it set.
- R3: Command bit 3 clears the interrupt line and command bit 4 sets it. When both are in one write, the line ends up high.
- R4: Single-step is status bit 5; command bit 5 clears it and bit 6 sets it. Interrupt-on-break is status bit 6; bit 7 clears it and bit 8 sets it. For each of these flags, set wins over clear.
- R5: Signal k (k = 0..7) is status bit 7+k. Command bit 9+2k clears it and bit 10+2k sets it, and set wins over clear.
- R6: A write whose command word has bit 0 or bit 2 set, and after which halt and broke are both 0, makes task_start high for exactly the next cycle. Any other cycle leaves task_start low.
- R7: A break event raises the interrupt line when interrupt-on-break was 1 before that cycle. With interrupt-on-break at 0, a break event leaves the line unchanged.
- R8: After reset, status reads 0x0001, the interrupt line is low and task_start is low.
- R9: With the write strobe low, the command word has no effect on any output. Status bits 2 to 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 25 | Set/clear command word |
| brk_evt | input | 1 | Break event from the processor core |
| status | output | 15 | Status word |
| irq | output | 1 | Interrupt line |
| task_start | output | 1 | One-cycle task-start pulse |

## Verification
Directed writes put set and clear bits for one flag in the same word, which separates a set-wins design from a clear-wins one. They also issue a resume while the other run flag is still set, which separates T_RESUME from T_REARM. A break event in the same cycle as a broke clear checks the priority of the event. Break events are sent with interrupt-on-break both on and off to show that the interrupt depends on that flag. Sparse random command words with random strobes and break events then compare every output against a bench model each cycle, so no flag can disturb its neighbours unnoticed and an idle strobe is shown to change nothing.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        RS_HALT     = 2'd0,
        RS_HALT_BRK = 2'd1,
        RS_BROKE    = 2'd2,
        RS_RUN      = 2'd3
    } run_state_t;

    localparam int CMD_CLR_HALT = 0;
    localparam int CMD_SET_HALT = 1;
    localparam int CMD_CLR_BRK  = 2;
    localparam int CMD_CLR_IRQ  = 3;
    localparam int CMD_SET_IRQ  = 4;
    localparam int CMD_FLAG0    = 5;
    localparam int STAT_HALT    = 0;
    localparam int STAT_BRK     = 1;
    localparam int STAT_FLAG0   = 5;
endpackage

// File: rtl/ssp_pair_flag.sv
module ssp_pair_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic clr_i,
    input  logic set_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (we_i && set_i)
            q_o <= 1'b1;
        else if (we_i && clr_i)
            q_o <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && set_i) |=> q_o); // R4
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && clr_i && !set_i) |=> !q_o); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o)); // R9
endmodule

// File: rtl/ssp_run_fsm.sv
module ssp_run_fsm
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic clr_halt_i,
    input  logic set_halt_i,
    input  logic clr_brk_i,
    input  logic brk_evt_i,
    output logic halt_o,
    output logic broke_o,
    output logic task_start_o
);
    run_state_t state_q, state_d;
    logic cur_h, cur_b, nxt_h, nxt_b, resume;

    always_comb begin
        unique case (state_q)
            RS_HALT:     begin cur_h = 1'b1; cur_b = 1'b0; end
            RS_HALT_BRK: begin cur_h = 1'b1; cur_b = 1'b1; end
            RS_BROKE:    begin cur_h = 1'b0; cur_b = 1'b1; end
            RS_RUN:      begin cur_h = 1'b0; cur_b = 1'b0; end
            default:     begin cur_h = 1'b1; cur_b = 1'b0; end
        endcase
        nxt_h = (we_i && set_halt_i) || (cur_h && !(we_i && clr_halt_i));
        nxt_b = brk_evt_i || (cur_b && !(we_i && clr_brk_i));
        unique case ({nxt_h, nxt_b})
            2'b10:   state_d = RS_HALT;
            2'b11:   state_d = RS_HALT_BRK;
            2'b01:   state_d = RS_BROKE;
            default: state_d = RS_RUN;
        endcase
        resume = we_i && (clr_halt_i || clr_brk_i) && (state_d == RS_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RS_HALT;
            task_start_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            task_start_o <= resume;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_HALT:     begin halt_o = 1'b1; broke_o = 1'b0; end
            RS_HALT_BRK: begin halt_o = 1'b1; broke_o = 1'b1; end
            RS_BROKE:    begin halt_o = 1'b0; broke_o = 1'b1; end
            RS_RUN:      begin halt_o = 1'b0; broke_o = 1'b0; end
            default:     begin halt_o = 1'b1; broke_o = 1'b0; end
        endcase
    end

    AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && set_halt_i) |=> halt_o); // R1
    AST_BRK_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt_i |=> broke_o); // R2
    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        task_start_o |-> (!halt_o && !broke_o)); // R6
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        task_start_o |-> $past(we_i && (clr_halt_i || clr_brk_i))); // R6
endmodule

// File: rtl/ssp_irq_ctl.sv
module ssp_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic clr_i,
    input  logic set_i,
    input  logic brk_evt_i,
    input  logic int_on_brk_i,
    output logic irq_o
);
    logic raise;

    assign raise = (we_i && set_i) || (brk_evt_i && int_on_brk_i);

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (raise)
            irq_o <= 1'b1;
        else if (we_i && clr_i)
            irq_o <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && set_i) |=> irq_o); // R3
    AST_IRQ_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt_i && int_on_brk_i) |=> irq_o); // R7
endmodule

// File: rtl/ssp_status_reg.sv
module ssp_status_reg
    import ssp_pkg::*;
#(
    parameter int NUM_SIG = 8,
    parameter int CMD_W   = 9 + 2 * NUM_SIG,
    parameter int STAT_W  = 7 + NUM_SIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              brk_evt,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              task_start
);
    localparam int NUM_FLAG = 2 + NUM_SIG;

    logic              halt, broke;
    logic [NUM_FLAG-1:0] flag_q;

    ssp_run_fsm u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (cmd_we),
        .clr_halt_i   (cmd_data[CMD_CLR_HALT]),
        .set_halt_i   (cmd_data[CMD_SET_HALT]),
        .clr_brk_i    (cmd_data[CMD_CLR_BRK]),
        .brk_evt_i    (brk_evt),
        .halt_o       (halt),
        .broke_o      (broke),
        .task_start_o (task_start)
    );

    for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
        ssp_pair_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .we_i  (cmd_we),
            .clr_i (cmd_data[CMD_FLAG0 + 2*i]),
            .set_i (cmd_data[CMD_FLAG0 + 2*i + 1]),
            .q_o   (flag_q[i])
        );
    end

    // flag index 1 is interrupt-on-break
    ssp_irq_ctl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (cmd_we),
        .clr_i        (cmd_data[CMD_CLR_IRQ]),
        .set_i        (cmd_data[CMD_SET_IRQ]),
        .brk_evt_i    (brk_evt),
        .int_on_brk_i (flag_q[1]),
        .irq_o        (irq)
    );

    always_comb begin
        status = '0;
        status[STAT_HALT] = halt;
        status[STAT_BRK]  = broke;
        status[STAT_W-1:STAT_FLAG0] = flag_q;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[4:2] == 3'b000); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !brk_evt) |=> $stable(status)); // R9
endmodule

// File: tb/sim_ssp_status_reg.sv
module sim_ssp_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 25;
    localparam int SW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [CW-1:0] cmd_data = '0;
    logic          brk_evt = 1'b0;
    logic [SW-1:0] status;
    logic          irq;
    logic          task_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [SW-1:0] m_stat;
    logic          m_irq;
    logic          m_ts;

    ssp_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .brk_evt(brk_evt), .status(status), .irq(irq), .task_start(task_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [SW-1:0] nxt_stat(logic [SW-1:0] s, logic we,
                                               logic [CW-1:0] c, logic b);
        logic [SW-1:0] r;
        r = s;
        if (we && c[0]) r[0] = 1'b0;
        if (we && c[1]) r[0] = 1'b1;
        if (we && c[2]) r[1] = 1'b0;
        if (b) r[1] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (we && c[5+2*i]) r[5+i] = 1'b0;
            if (we && c[6+2*i]) r[5+i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic nxt_irq(logic q, logic [SW-1:0] s, logic we,
                                     logic [CW-1:0] c, logic b);
        logic r;
        r = q;
        if (we && c[3]) r = 1'b0;
        if ((we && c[4]) || (b && s[6])) r = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic we, logic [CW-1:0] c, logic b, string tag);
        logic [SW-1:0] ns;
        @(negedge clk);
        cmd_we = we; cmd_data = c; brk_evt = b;
        ns = nxt_stat(m_stat, we, c, b);
        m_irq = nxt_irq(m_irq, m_stat, we, c, b);
        m_ts = we && (c[0] || c[2]) && !ns[0] && !ns[1];
        m_stat = ns;
        @(posedge clk);
        #1;
        check(tag, "status", int'(status), int'(m_stat));
        check(tag, "irq", int'(irq), int'(m_irq));
        check(tag, "task_start", int'(task_start), int'(m_ts));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_stat = 15'h0001; m_irq = 1'b0; m_ts = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8", "status", int'(status), 32'h0001);
        check("R8", "irq", int'(irq), 0);
        check("R8", "task_start", int'(task_start), 0);

        step(1'b1, 25'h1, 1'b0, "R1 R6 resume");
        check("R6", "pulse", int'(task_start), 1);
        step(1'b0, 25'h0, 1'b0, "R6 one wide");
        check("R6", "pulse end", int'(task_start), 0);
        step(1'b1, 25'h3, 1'b0, "R1 set wins");
        check("R1", "halt", int'(status[0]), 1);
        step(1'b0, 25'h0, 1'b1, "R2 R7 brk no irq");
        check("R7", "irq off", int'(irq), 0);
        step(1'b1, 25'h100, 1'b0, "R4 intbrk set");
        step(1'b0, 25'h0, 1'b1, "R7 brk irq");
        check("R7", "irq on", int'(irq), 1);
        step(1'b1, 25'h8, 1'b0, "R3 irq clr");
        step(1'b1, 25'h18, 1'b0, "R3 set wins");
        check("R3", "irq", int'(irq), 1);
        step(1'b1, 25'h4, 1'b0, "R6 rearm no pulse");
        check("R6", "no pulse", int'(task_start), 0);
        step(1'b1, 25'h1, 1'b1, "R2 brk over clr");
        check("R2", "broke", int'(status[1]), 1);
        step(1'b1, 25'h4, 1'b0, "R6 resume broke");
        step(1'b1, 25'h1000040, 1'b0, "R4 R5 sstep sig7");
        check("R5", "sig7", int'(status[14]), 1);
        step(1'b1, 25'h1800000, 1'b0, "R5 set wins");
        step(1'b0, 25'h1FFFFFF, 1'b0, "R9 idle strobe");

        for (int i = 0; i < 3000; i++) begin
            logic [CW-1:0] c;
            c = CW'($urandom() & $urandom() & $urandom());
            step(($urandom() % 2) == 0, c, ($urandom() % 12) == 0,
                 "R1 R2 R3 R4 R5 R6 R7 R9 random");
        end
        finish_run();
    end
endmodule